// File: doc/BRIEF.md
# Character display host register interface

This block is the host-side controller core of a two-line character display. A host processor talks to it through an 8-bit data bus and a register-select line. The bus can be driven in one of two styles. In the first, one read/write level is qualified by an enable strobe. In the second, there are separate active-low read and write strobes. The `mode_i` pin chooses the style. Register select low addresses the instruction register on writes and the status word on reads. Register select high addresses the data register.

An address counter is shared by a 128-byte display memory and a 64-byte glyph memory. Line one of the panel sits at 00h-13h and line two at 40h-53h. Data writes go straight into whichever memory is selected at the counter, and the counter then steps. Data reads are served from a data register that is refilled in the background. The refill happens after an address instruction and after every data read, so consecutive reads stream through memory. A busy flag covers each internal operation. It is reported in the top bit of the status word, beside the counter. The clear instruction walks the whole display memory, one byte per clock.

Top module: `chr_disp_host_if`

## Requirements
- R1: After reset the status word reads 00h (not busy, counter 0), `db_o` is 00h, display memory is selected and the counter steps upward.
- R2: A status read (rs_i=0, read) places {busy, counter[6:0]} on `db_o` at the clock edge of the access. It is served even while busy and never starts a busy period.
- R3: Instruction codes 80h-FFh load the counter with bits 6:0, select display memory, and load the data register from that address on the next clock.
- R4: Instruction codes 40h-7Fh load the counter with bits 5:0, select glyph memory, and prefetch from that address.
- R5: A data write (rs_i=1) stores `db_i` into the selected memory at the counter, then steps the counter.
- R6: A data read returns the data register on `db_o`, steps the counter, and reloads the data register from the new address, so successive reads return successive bytes.
- R7: Instruction codes 04h-07h set the step direction: bit 1 = 1 steps up, bit 1 = 0 steps down.
- R8: The counter wraps modulo 128 in display memory (7Fh+1 = 00h, 00h-1 = 7Fh) and modulo 64 in glyph memory (3Fh+1 = 00h). In glyph memory it never exceeds 3Fh.
- R9: An accepted data access or recognised instruction holds busy for exactly BUSY_CYC (default 3) clocks. Clear holds it for 130 clocks.
- R10: While busy, instruction writes, data writes and data reads are ignored: counter, memories, selection and `db_o` are unchanged.
- R11: Instruction code 01h fills all 128 display bytes with 20h, sets the counter to 0, selects display memory and restores upward stepping.
- R12: With mode_i=0, an access happens once per rising edge of `en_i`, and rw_i=1 means read. With mode_i=1, a falling `rd_ni` is a read and a falling `wr_ni` is a write. If both fall in the same clock, only the read is performed.
- R13: Any other instruction code (00h, 02h-03h, 08h-3Fh) has no effect and does not set busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Bus style: 0 = level read/write with enable, 1 = separate read/write strobes |
| rs_i | input | 1 | Register select: 0 = instruction/status, 1 = data |
| rw_i | input | 1 | Read (1) or write (0), style 0 only |
| en_i | input | 1 | Enable strobe, access on rising edge, style 0 only |
| rd_ni | input | 1 | Read strobe, active low, style 1 only |
| wr_ni | input | 1 | Write strobe, active low, style 1 only |
| db_i | input | 8 | Host write data / instruction code |
| db_o | output | 8 | Host read data or status word, registered |

## Verification
The assertions take the host pins to be synchronous to `clk_i`. They assume `rd_ni` and `wr_ni` are held high through reset, so that no strobe edge appears at the first clock after release. They also assume the host reads memory only at addresses it has written or cleared. The stimulus changes every pin on the falling clock edge and parks both strobes high during reset. It waits out each busy period before the next access, except in the cases aimed at the busy window. It reads back only bytes that it wrote earlier or that a clear filled.

// File: rtl/chr_disp_pkg.sv
package chr_disp_pkg;

  typedef enum logic [2:0] {
    INS_NONE,
    INS_CLEAR,
    INS_ENTRY,
    INS_SET_CG,
    INS_SET_DD
  } ins_e;

  localparam logic [7:0] BLANK_CHAR = 8'h20;

  function automatic ins_e decode_ins(input logic [7:0] code);
    if (code[7])                  return INS_SET_DD;
    else if (code[6])             return INS_SET_CG;
    else if (code[5:2] == 4'b0001) return INS_ENTRY;
    else if (code == 8'h01)       return INS_CLEAR;
    else                          return INS_NONE;
  endfunction

endpackage

// File: rtl/chr_bus_dec.sv
module chr_bus_dec (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_i,
  input  logic rw_i,
  input  logic en_i,
  input  logic rd_ni,
  input  logic wr_ni,
  output logic acc_v_o,
  output logic acc_rd_o
);

  logic en_q, rd_q, wr_q;
  logic en_rise, rd_fall, wr_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0;
      rd_q <= 1'b1;
      wr_q <= 1'b1;
    end else begin
      en_q <= en_i;
      rd_q <= rd_ni;
      wr_q <= wr_ni;
    end
  end

  assign en_rise = en_i & ~en_q;
  assign rd_fall = rd_q & ~rd_ni;
  assign wr_fall = wr_q & ~wr_ni;

  always_comb begin
    if (mode_i) begin
      acc_v_o  = rd_fall | wr_fall;
      acc_rd_o = rd_fall;  // read wins a simultaneous strobe
    end else begin
      acc_v_o  = en_rise;
      acc_rd_o = rw_i;
    end
  end

endmodule

// File: rtl/chr_busy_tmr.sv
module chr_busy_tmr #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             busy_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
  end

  assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/chr_ram.sv
module chr_ram #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];

endmodule

// File: rtl/chr_disp_host_if.sv
module chr_disp_host_if
  import chr_disp_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CG_DEPTH = 64,
  parameter int BUSY_CYC = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              rs_i,
  input  logic              rw_i,
  input  logic              en_i,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [DATA_W-1:0] db_i,
  output logic [DATA_W-1:0] db_o
);

  localparam int AC_W     = DATA_W - 1;
  localparam int DD_DEPTH = 1 << AC_W;
  localparam int CG_AW    = $clog2(CG_DEPTH);
  localparam int CLR_CYC  = DD_DEPTH + 2;
  localparam int CNT_W    = $clog2(CLR_CYC + 1);
  localparam logic [AC_W-1:0] CG_MASK = AC_W'(CG_DEPTH - 1);

  logic              acc_v, acc_rd, busy;
  logic [AC_W-1:0]   ac_q, ac_step, ac_wrap, clr_idx_q;
  logic              sel_cg_q, inc_q, pf_q, clr_act_q;
  logic [DATA_W-1:0] dr_q, dd_rdata, cg_rdata;
  ins_e              ins;
  logic              go, st_rd, ins_ok, dat_wr, dat_rd, busy_load;
  logic [CNT_W-1:0]  busy_val;

  chr_bus_dec u_dec (
    .clk_i, .rst_ni, .mode_i, .rw_i, .en_i, .rd_ni, .wr_ni,
    .acc_v_o (acc_v),
    .acc_rd_o(acc_rd)
  );

  assign ins    = decode_ins(db_i[7:0]);
  assign go     = acc_v & ~busy;
  assign st_rd  = acc_v & acc_rd & ~rs_i;
  assign ins_ok = go & ~rs_i & ~acc_rd & (ins != INS_NONE);
  assign dat_wr = go & rs_i & ~acc_rd;
  assign dat_rd = go & rs_i & acc_rd;

  assign busy_load = ins_ok | dat_wr | dat_rd;
  assign busy_val  = (ins_ok && ins == INS_CLEAR) ? CNT_W'(CLR_CYC) : CNT_W'(BUSY_CYC);

  chr_busy_tmr #(.CNT_W(CNT_W)) u_busy (
    .clk_i, .rst_ni,
    .load_i(busy_load),
    .val_i (busy_val),
    .busy_o(busy)
  );

  always_comb begin
    ac_step = inc_q ? ac_q + AC_W'(1) : ac_q - AC_W'(1);
    ac_wrap = sel_cg_q ? (ac_step & CG_MASK) : ac_step;
  end

  chr_ram #(.DEPTH(DD_DEPTH), .W(DATA_W)) u_dd_ram (
    .clk_i,
    .we_i   (clr_act_q | (dat_wr & ~sel_cg_q)),
    .waddr_i(clr_act_q ? clr_idx_q : ac_q),
    .wdata_i(clr_act_q ? DATA_W'(BLANK_CHAR) : db_i),
    .raddr_i(ac_q),
    .rdata_o(dd_rdata)
  );

  chr_ram #(.DEPTH(CG_DEPTH), .W(DATA_W)) u_cg_ram (
    .clk_i,
    .we_i   (dat_wr & sel_cg_q),
    .waddr_i(ac_q[CG_AW-1:0]),
    .wdata_i(db_i),
    .raddr_i(ac_q[CG_AW-1:0]),
    .rdata_o(cg_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ac_q      <= '0;
      sel_cg_q  <= 1'b0;
      inc_q     <= 1'b1;
      dr_q      <= '0;
      db_o      <= '0;
      pf_q      <= 1'b0;
      clr_act_q <= 1'b0;
      clr_idx_q <= '0;
    end else begin
      pf_q <= 1'b0;
      if (pf_q) dr_q <= sel_cg_q ? cg_rdata : dd_rdata;
      if (clr_act_q) begin
        clr_idx_q <= clr_idx_q + AC_W'(1);
        if (clr_idx_q == AC_W'(DD_DEPTH - 1)) clr_act_q <= 1'b0;
      end
      if (st_rd) db_o <= {busy, ac_q};
      if (dat_rd) begin
        db_o <= dr_q;
        ac_q <= ac_wrap;
        pf_q <= 1'b1;
      end
      if (dat_wr) ac_q <= ac_wrap;
      if (ins_ok) begin
        unique case (ins)
          INS_CLEAR: begin
            ac_q      <= '0;
            sel_cg_q  <= 1'b0;
            inc_q     <= 1'b1;
            clr_act_q <= 1'b1;
            clr_idx_q <= '0;
          end
          INS_ENTRY: inc_q <= db_i[1];
          INS_SET_CG: begin
            ac_q     <= AC_W'(db_i[CG_AW-1:0]);
            sel_cg_q <= 1'b1;
            pf_q     <= 1'b1;
          end
          INS_SET_DD: begin
            ac_q     <= db_i[AC_W-1:0];
            sel_cg_q <= 1'b0;
            pf_q     <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/chr_disp_host_chk.sv
module chr_disp_host_chk #(
  parameter int AC_W     = 7,
  parameter int CG_DEPTH = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            mode_i,
  input logic            rs_i,
  input logic            rd_ni,
  input logic            wr_ni,
  input logic            acc_v,
  input logic            acc_rd,
  input logic            busy,
  input logic [AC_W-1:0] ac_q,
  input logic            sel_cg_q,
  input logic            clr_act_q
);

  // R9
  data_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_v && !busy && rs_i) |=> busy);

  // R2
  status_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_v && acc_rd && !rs_i && !busy) |=> !busy);

  // R10
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> ($stable(ac_q) && $stable(sel_cg_q)));

  // R8
  cg_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_cg_q |-> (ac_q < AC_W'(CG_DEPTH)));

  // R11
  clr_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_act_q |-> busy);

  // R12
  strobe_pri_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && $fell(rd_ni) && $fell(wr_ni)) |-> (acc_v && acc_rd));

endmodule

bind chr_disp_host_if chr_disp_host_chk #(.AC_W(AC_W), .CG_DEPTH(CG_DEPTH)) u_chk (
  .clk_i, .rst_ni, .mode_i, .rs_i, .rd_ni, .wr_ni,
  .acc_v, .acc_rd, .busy, .ac_q, .sel_cg_q, .clr_act_q
);

// File: tb/chr_disp_host_if_tb.sv
`timescale 1ns/1ps
module chr_disp_host_if_tb;

  localparam int BUSY_CYC = 3;
  localparam int CLR_CYC  = 130;
  localparam int IDLE     = BUSY_CYC + 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic mode = 1'b0, rs = 1'b0, rw = 1'b0, en = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] db_in = '0;
  logic [7:0] db_out;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  chr_disp_host_if #(.BUSY_CYC(BUSY_CYC)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .rs_i(rs), .rw_i(rw),
    .en_i(en), .rd_ni(rd_n), .wr_ni(wr_n), .db_i(db_in), .db_o(db_out)
  );

  typedef struct packed {
    logic       m;
    logic       rs;
    logic       rd;
    logic       chk;
    logic [7:0] din;
    logic [7:0] exp;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0,8'h80,8'h00,8'd3},   // R3 set display addr 0
    '{1'b0,1'b1,1'b0,1'b0,8'h41,8'h00,8'd5},   // R5
    '{1'b0,1'b1,1'b0,1'b0,8'h42,8'h00,8'd5},
    '{1'b0,1'b0,1'b1,1'b1,8'h00,8'h02,8'd5},   // R5 counter stepped twice
    '{1'b0,1'b0,1'b0,1'b0,8'h80,8'h00,8'd3},
    '{1'b0,1'b1,1'b1,1'b1,8'h00,8'h41,8'd3},   // R3 prefetch
    '{1'b0,1'b1,1'b1,1'b1,8'h00,8'h42,8'd6},   // R6 streaming
    '{1'b0,1'b0,1'b1,1'b1,8'h00,8'h02,8'd2},   // R2
    '{1'b0,1'b0,1'b0,1'b0,8'hFF,8'h00,8'd8},
    '{1'b0,1'b1,1'b0,1'b0,8'h5A,8'h00,8'd8},
    '{1'b0,1'b0,1'b1,1'b1,8'h00,8'h00,8'd8},   // R8 7F+1 -> 00
    '{1'b0,1'b0,1'b0,1'b0,8'h04,8'h00,8'd7},   // R7 step down
    '{1'b0,1'b0,1'b0,1'b0,8'h81,8'h00,8'd7},
    '{1'b0,1'b1,1'b1,1'b1,8'h00,8'h42,8'd7},
    '{1'b0,1'b1,1'b1,1'b1,8'h00,8'h41,8'd7},
    '{1'b0,1'b1,1'b1,1'b1,8'h00,8'h5A,8'd8},   // R8 00-1 -> 7F
    '{1'b0,1'b0,1'b1,1'b1,8'h00,8'h7E,8'd7},
    '{1'b0,1'b0,1'b0,1'b0,8'h06,8'h00,8'd7},   // step up
    '{1'b0,1'b0,1'b0,1'b0,8'h7F,8'h00,8'd4},   // R4 glyph addr 3F
    '{1'b0,1'b0,1'b1,1'b1,8'h00,8'h3F,8'd4},
    '{1'b0,1'b1,1'b0,1'b0,8'h11,8'h00,8'd4},
    '{1'b0,1'b0,1'b1,1'b1,8'h00,8'h00,8'd8},   // R8 3F+1 -> 00
    '{1'b0,1'b1,1'b0,1'b0,8'h12,8'h00,8'd4},
    '{1'b0,1'b0,1'b0,1'b0,8'h7F,8'h00,8'd4},
    '{1'b0,1'b1,1'b1,1'b1,8'h00,8'h11,8'd4},
    '{1'b0,1'b1,1'b1,1'b1,8'h00,8'h12,8'd6},
    '{1'b1,1'b0,1'b0,1'b0,8'h80,8'h00,8'd12},  // R12 strobe style
    '{1'b1,1'b1,1'b1,1'b1,8'h00,8'h41,8'd12},
    '{1'b1,1'b1,1'b0,1'b0,8'h33,8'h00,8'd12},
    '{1'b1,1'b0,1'b0,1'b0,8'h81,8'h00,8'd12},
    '{1'b1,1'b1,1'b1,1'b1,8'h00,8'h33,8'd12},
    '{1'b1,1'b0,1'b1,1'b1,8'h00,8'h02,8'd12},
    '{1'b0,1'b0,1'b0,1'b0,8'h00,8'h00,8'd13},  // R13 no-op code
    '{1'b0,1'b0,1'b1,1'b1,8'h00,8'h02,8'd13},
    '{1'b0,1'b0,1'b0,1'b0,8'h10,8'h00,8'd13},
    '{1'b0,1'b0,1'b1,1'b1,8'h00,8'h02,8'd13}
  };

  task automatic check(input logic [7:0] got, input logic [7:0] exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic acc(input logic m, input logic r_s, input logic rd, input logic [7:0] d);
    @(negedge clk);
    mode = m; rs = r_s; db_in = d;
    if (!m) begin rw = rd; en = 1'b1; end
    else if (rd) rd_n = 1'b0;
    else wr_n = 1'b0;
    @(negedge clk);
    en = 1'b0; rd_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(1);
    check(db_out, 8'h00, "R1 db_o after reset");
    acc(0, 0, 1, 8'h00);
    check(db_out, 8'h00, "R1 status after reset");
    idle(IDLE);

    for (int i = 0; i < NV; i++) begin
      acc(VEC[i].m, VEC[i].rs, VEC[i].rd, VEC[i].din);
      if (VEC[i].chk) check(db_out, VEC[i].exp, $sformatf("R%0d vector %0d", VEC[i].req, i));
      idle(IDLE);
    end

    // R9 busy window of exactly BUSY_CYC clocks
    acc(0, 0, 0, 8'h85);
    acc(0, 0, 1, 8'h00);
    check(db_out, 8'h85, "R9 busy set");
    acc(0, 0, 1, 8'h00);
    check(db_out, 8'h05, "R9 busy cleared");
    idle(IDLE);

    // R10 accesses during busy are dropped
    acc(0, 0, 0, 8'h85);
    acc(0, 0, 0, 8'h90);
    idle(IDLE);
    acc(0, 0, 1, 8'h00);
    check(db_out, 8'h05, "R10 instruction ignored");
    idle(IDLE);
    acc(0, 0, 0, 8'h80);
    acc(0, 1, 0, 8'h77);
    idle(IDLE);
    acc(0, 0, 1, 8'h00);
    check(db_out, 8'h00, "R10 data write ignored counter");
    idle(IDLE);
    acc(0, 1, 1, 8'h00);
    check(db_out, 8'h41, "R10 data write ignored memory");
    idle(IDLE);
    acc(0, 0, 1, 8'h00);
    check(db_out, 8'h01, "R6 counter after read");
    acc(0, 0, 0, 8'h80);
    acc(0, 1, 1, 8'h00);
    check(db_out, 8'h01, "R10 data read ignored");
    idle(IDLE);

    // R13 unknown code leaves busy low
    acc(0, 0, 0, 8'h00);
    acc(0, 0, 1, 8'h00);
    check(db_out, 8'h00, "R13 no busy");
    idle(IDLE);

    // R11 clear display
    acc(0, 0, 0, 8'h04);
    idle(IDLE);
    acc(0, 0, 0, 8'h01);
    acc(0, 0, 1, 8'h00);
    check(db_out, 8'h80, "R11 clear busy");
    idle(CLR_CYC + 4);
    acc(0, 0, 1, 8'h00);
    check(db_out, 8'h00, "R11 clear done counter 0");
    idle(IDLE);
    acc(0, 0, 0, 8'h80);
    idle(IDLE);
    acc(0, 1, 1, 8'h00);
    check(db_out, 8'h20, "R11 blank at 00");
    idle(IDLE);
    acc(0, 1, 1, 8'h00);
    check(db_out, 8'h20, "R11 blank at 01");
    idle(IDLE);
    acc(0, 0, 1, 8'h00);
    check(db_out, 8'h02, "R11 step up restored");
    idle(IDLE);
    acc(0, 0, 0, 8'hFF);
    idle(IDLE);
    acc(0, 1, 1, 8'h00);
    check(db_out, 8'h20, "R11 blank at 7F");
    idle(IDLE);

    // R12 simultaneous strobes: read only
    acc(1, 0, 0, 8'h80);
    idle(IDLE);
    @(negedge clk);
    mode = 1'b1; rs = 1'b1; db_in = 8'h99; rd_n = 1'b0; wr_n = 1'b0;
    @(negedge clk);
    rd_n = 1'b1; wr_n = 1'b1;
    check(db_out, 8'h20, "R12 both strobes read");
    idle(IDLE);
    acc(1, 0, 0, 8'h80);
    idle(IDLE);
    acc(1, 1, 1, 8'h00);
    check(db_out, 8'h20, "R12 both strobes no write");
    idle(IDLE);

    // R12 held enable gives one access
    acc(0, 0, 0, 8'h80);
    idle(IDLE);
    @(negedge clk);
    mode = 1'b0; rs = 1'b1; rw = 1'b1; en = 1'b1;
    idle(10);
    en = 1'b0;
    idle(IDLE);
    acc(0, 0, 1, 8'h00);
    check(db_out, 8'h01, "R12 held enable single step");

    finish_run();
  end

endmodule